// File: doc/BRIEF.md
# Carrier Divider and Phase Meter

This block turns a system clock of 4, 8, 12 or 16 MHz into a fixed 125 kHz square-wave carrier. It drives that carrier onto a pair of complementary full-bridge outputs. A two-bit select code picks the division ratio. The drivers can be switched off either by a transmit-disable level or by a write-modulation request from the modulator. When switched off, both bridge legs go low.

Each carrier period, the block also times the first rising edge of the digitised antenna tap signal against the rising edge of the first driver leg. It expresses that delay in 64ths of a period as a six-bit code. The code is published once per period, together with a one-cycle strobe. If no tap edge arrived during the period, a flag is raised instead and the previous code is kept. Software can then derive a demodulator sampling point that compensates for antenna detuning. With a well-tuned coil the code sits near 16, which is a quarter period.

Top module: `carrier_phase_unit`

## Requirements
- R1: The carrier period is 32, 64, 96 or 128 clocks for select codes 00, 01, 10 and 11. `tx_a` is high for the first half of the period and low for the second half.
- R2: While the drivers are enabled, `tx_b` is always the inverse of `tx_a`.
- R3: A high `tx_dis` forces both `tx_a` and `tx_b` low from the next clock on. The period count keeps running. `tx_dis` is expected high at reset.
- R4: A high `mod_off` forces both driver outputs low in the same way as `tx_dis`.
- R5: Let c be the number of clock edges from the edge at which `tx_a` rises to the first edge that samples `tap_in` high after sampling it low. Then `phase_code` = floor(c*64/P), where P is the period in clocks. A 90-degree lag gives 16.
- R6: `period_stb` is high for exactly one clock per period, in the cycle just before `tx_a` rises. `phase_code` and `no_edge` change only in that cycle.
- R7: If a period contains no rising tap edge, `phase_code` keeps its value and `no_edge` is 1 from the strobe on. The next period that has an edge clears `no_edge`.
- R8: Only the first rising tap edge in a period is measured. Later edges in the same period are ignored.
- R9: A new select code takes effect only at the next period boundary. The period in progress finishes at its old length.
- R10: During and right after reset, both driver outputs, `phase_code`, `no_edge` and `period_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (4 to 16 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| freq_sel | input | 2 | Clock frequency select code |
| tx_dis | input | 1 | Transmit disable, 1 = drivers off |
| mod_off | input | 1 | Write-modulation request, 1 = drivers off |
| tap_in | input | 1 | Digitised antenna tap comparator |
| tx_a | output | 1 | Bridge leg A |
| tx_b | output | 1 | Bridge leg B |
| phase_code | output | 6 | Last measured phase in 64ths of a period |
| no_edge | output | 1 | Last period had no tap edge |
| period_stb | output | 1 | One-cycle strobe per carrier period |

## Verification
The tap signal is driven with a single pulse per period at various offsets under three select codes. Each offset lands on a distinct floor(c*64/P) value, which tells the 2-per-clock, 1-per-clock and fractional 96-clock scalings apart. A period with two pulses separates first-edge capture from last-edge capture. A silent period shows whether the code is held and the flag raised. A select change in mid-period reveals whether the period length switches early. Pulses of `mod_off` and `tx_dis` show that the bridge goes low while the period count runs on.

// File: rtl/carrier_pkg.sv
package carrier_pkg;
  localparam int BASE_CLKS = 32;
  localparam int SEL_W     = 2;
  localparam int NUM_SEL   = 1 << SEL_W;
  localparam int CNT_W     = $clog2(BASE_CLKS * NUM_SEL);
  localparam int PER_W     = CNT_W + 1;
  localparam int PH_W      = 6;
  localparam int PH_STEPS  = 1 << PH_W;
  localparam int FRAC_W    = 11;
  localparam int MUL_W     = FRAC_W + PH_W - $clog2(BASE_CLKS) + 1;

  function automatic logic [PER_W-1:0] period_of(input logic [SEL_W-1:0] s);
    return PER_W'(BASE_CLKS * (int'(s) + 1));
  endfunction

  // scale factor so that (count * factor) >> FRAC_W = floor(count * 64 / period)
  function automatic logic [MUL_W-1:0] scale_of(input logic [SEL_W-1:0] s);
    int p;
    p = BASE_CLKS * (int'(s) + 1);
    return MUL_W'(((PH_STEPS << FRAC_W) + p - 1) / p);
  endfunction
endpackage

// File: rtl/carrier_timebase.sv
module carrier_timebase
  import carrier_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] freq_sel,
  output logic [CNT_W-1:0] cnt,
  output logic [MUL_W-1:0] scale,
  output logic             wrap,
  output logic             first_half
);
  logic [SEL_W-1:0] sel_q;
  logic [PER_W-1:0] per;

  assign per        = period_of(sel_q);
  assign scale      = scale_of(sel_q);
  assign wrap       = (PER_W'(cnt) == per - PER_W'(1));
  assign first_half = (PER_W'(cnt) < (per >> 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sel_q <= freq_sel;
    end else if (wrap) begin
      cnt   <= '0;
      sel_q <= freq_sel;
    end else begin
      cnt   <= cnt + CNT_W'(1);
    end
  end

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
    PER_W'(cnt) < period_of(sel_q));
  assert_wrap_restart_R9: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));
endmodule

// File: rtl/bridge_driver.sv
module bridge_driver (
  input  logic clk,
  input  logic rst,
  input  logic first_half,
  input  logic tx_dis,
  input  logic mod_off,
  output logic tx_a,
  output logic tx_b
);
  logic enable;
  assign enable = !tx_dis && !mod_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_a <= 1'b0;
      tx_b <= 1'b0;
    end else begin
      tx_a <= enable &&  first_half;
      tx_b <= enable && !first_half;
    end
  end

  assert_legs_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(tx_a && tx_b));
  assert_dis_low_R3: assert property (@(posedge clk) disable iff (rst)
    tx_dis |=> (!tx_a && !tx_b));
  assert_modoff_low_R4: assert property (@(posedge clk) disable iff (rst)
    mod_off |=> (!tx_a && !tx_b));
endmodule

// File: rtl/phase_meter.sv
module phase_meter
  import carrier_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tap_in,
  input  logic [CNT_W-1:0] cnt,
  input  logic [MUL_W-1:0] scale,
  input  logic             wrap,
  output logic [PH_W-1:0]  phase_code,
  output logic             no_edge,
  output logic             period_stb
);
  localparam int PROD_W = CNT_W + MUL_W;

  logic                tap_q;
  logic                seen;
  logic [PH_W-1:0]     held;
  logic [PROD_W-1:0]   prod;
  logic [PH_W-1:0]     ph_now;
  logic                rise;
  logic                seen_n;
  logic [PH_W-1:0]     held_n;

  assign prod   = PROD_W'(cnt) * PROD_W'(scale);
  assign ph_now = prod[FRAC_W +: PH_W];
  assign rise   = tap_in && !tap_q;
  assign seen_n = seen || rise;
  assign held_n = (rise && !seen) ? ph_now : held;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_q      <= 1'b1;
      seen       <= 1'b0;
      held       <= '0;
      phase_code <= '0;
      no_edge    <= 1'b0;
      period_stb <= 1'b0;
    end else begin
      tap_q      <= tap_in;
      period_stb <= wrap;
      if (wrap) begin
        seen <= 1'b0;
        held <= '0;
        if (seen_n) begin
          phase_code <= held_n;
          no_edge    <= 1'b0;
        end else begin
          no_edge    <= 1'b1;
        end
      end else begin
        seen <= seen_n;
        held <= held_n;
      end
    end
  end

  assert_update_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    !period_stb |-> ($stable(phase_code) && $stable(no_edge)));
  assert_silent_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (period_stb && no_edge) |-> $stable(phase_code));
endmodule

// File: rtl/carrier_phase_unit.sv
module carrier_phase_unit
  import carrier_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] freq_sel,
  input  logic             tx_dis,
  input  logic             mod_off,
  input  logic             tap_in,
  output logic             tx_a,
  output logic             tx_b,
  output logic [PH_W-1:0]  phase_code,
  output logic             no_edge,
  output logic             period_stb
);
  logic [CNT_W-1:0] cnt;
  logic [MUL_W-1:0] scale;
  logic             wrap;
  logic             first_half;

  carrier_timebase u_timebase (
    .clk(clk), .rst(rst), .freq_sel(freq_sel),
    .cnt(cnt), .scale(scale), .wrap(wrap), .first_half(first_half)
  );

  bridge_driver u_driver (
    .clk(clk), .rst(rst), .first_half(first_half),
    .tx_dis(tx_dis), .mod_off(mod_off), .tx_a(tx_a), .tx_b(tx_b)
  );

  phase_meter u_meter (
    .clk(clk), .rst(rst), .tap_in(tap_in), .cnt(cnt), .scale(scale),
    .wrap(wrap), .phase_code(phase_code), .no_edge(no_edge),
    .period_stb(period_stb)
  );

  assert_strobe_at_start_R6: assert property (@(posedge clk) disable iff (rst)
    period_stb |-> (cnt == '0));
endmodule

// File: tb/carrier_phase_unit_tb.sv
module carrier_phase_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] freq_sel = 2'd3;
  logic       tx_dis = 1'b1;
  logic       mod_off = 1'b0;
  logic       tap_in = 1'b0;
  logic       tx_a, tx_b, no_edge, period_stb;
  logic [5:0] phase_code;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int m_cnt = 0, m_sel = 3, m_tapq = 1, m_seen = 0, m_hold = 0;
  int m_txa = 0, m_txb = 0, m_phase = 0, m_noedge = 0, m_stb = 0;
  bit started = 0;

  // tap stimulus: pulse offsets within the period, -1 = none
  int off1 = -1, off2 = -1;

  carrier_phase_unit u_dut (
    .clk(clk), .rst(rst), .freq_sel(freq_sel), .tx_dis(tx_dis),
    .mod_off(mod_off), .tap_in(tap_in), .tx_a(tx_a), .tx_b(tx_b),
    .phase_code(phase_code), .no_edge(no_edge), .period_stb(period_stb)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    int per, ph, rise, seen_n, hold_n, en;
    if (rst) begin
      m_cnt = 0; m_sel = int'(freq_sel); m_tapq = 1; m_seen = 0; m_hold = 0;
      m_txa = 0; m_txb = 0; m_phase = 0; m_noedge = 0; m_stb = 0;
      started = 1;
    end else begin
      per = 32 * (m_sel + 1);
      ph = (m_cnt * 64) / per;
      rise = (tap_in && !m_tapq) ? 1 : 0;
      seen_n = m_seen | rise;
      hold_n = (rise && !m_seen) ? ph : m_hold;
      en = (!tx_dis && !mod_off) ? 1 : 0;
      m_txa = (en && m_cnt < per / 2) ? 1 : 0;
      m_txb = (en && m_cnt >= per / 2) ? 1 : 0;
      m_tapq = tap_in ? 1 : 0;
      if (m_cnt == per - 1) begin
        m_stb = 1;
        if (seen_n != 0) begin m_phase = hold_n; m_noedge = 0; end
        else m_noedge = 1;
        m_seen = 0; m_hold = 0; m_cnt = 0; m_sel = int'(freq_sel);
      end else begin
        m_stb = 0; m_seen = seen_n; m_hold = hold_n; m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // every-clock comparison and tap drive
  always @(negedge clk) begin
    cycles++;
    if (started && !done) begin
      chk("R1 tx_a", int'(tx_a), m_txa);
      chk("R2 tx_b", int'(tx_b), m_txb);
      chk("R5 phase_code", int'(phase_code), m_phase);
      chk("R7 no_edge", int'(no_edge), m_noedge);
      chk("R6 period_stb", int'(period_stb), m_stb);
    end
    tap_in <= ((off1 >= 0 && m_cnt >= off1 && m_cnt < off1 + 4) ||
               (off2 >= 0 && m_cnt >= off2 && m_cnt < off2 + 4));
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_strobes(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      #1;
      if (period_stb) k++;
    end
  endtask

  task automatic strobe_gap(output int gap);
    gap = 0;
    wait_strobes(1);
    do begin
      @(negedge clk);
      #1;
      gap++;
    end while (!period_stb);
  endtask

  initial begin
    int gap;
    repeat (4) @(negedge clk);
    #1;
    // R10: reset state
    chk("R10 tx_a", int'(tx_a), 0);
    chk("R10 tx_b", int'(tx_b), 0);
    chk("R10 phase", int'(phase_code), 0);
    chk("R10 strobe", int'(period_stb), 0);
    @(negedge clk);
    rst = 1'b0;
    // R3: disabled from reset, bridge stays low
    repeat (40) @(negedge clk);
    #1;
    chk("R3 tx_a low", int'(tx_a), 0);
    chk("R3 tx_b low", int'(tx_b), 0);
    tx_dis = 1'b0;
    off1 = 32;
    wait_strobes(3);
    chk("R5 quarter lag at 16MHz", int'(phase_code), 16);
    strobe_gap(gap);
    chk("R1 period sel11", gap, 128);

    // R9: change select mid-period; current period keeps old length
    repeat (20) @(negedge clk);
    freq_sel = 2'd0;
    off1 = 10;
    wait_strobes(1);
    strobe_gap(gap);
    chk("R9 new period sel00", gap, 32);
    wait_strobes(2);
    chk("R5 phase sel00", int'(phase_code), 20);

    freq_sel = 2'd2;
    off1 = 50;
    wait_strobes(3);
    strobe_gap(gap);
    chk("R1 period sel10", gap, 96);
    chk("R5 phase sel10", int'(phase_code), 33);

    // R8: two edges per period, first one wins
    off1 = 20;
    off2 = 60;
    wait_strobes(3);
    chk("R8 first edge", int'(phase_code), 13);
    chk("R7 edge clears flag", int'(no_edge), 0);

    // R7: silent periods
    off1 = -1;
    off2 = -1;
    wait_strobes(3);
    chk("R7 no_edge set", int'(no_edge), 1);
    chk("R7 phase held", int'(phase_code), 13);

    // R4: modulation request
    off1 = 40;
    mod_off = 1'b1;
    repeat (70) @(negedge clk);
    #1;
    chk("R4 tx_a low", int'(tx_a), 0);
    chk("R4 tx_b low", int'(tx_b), 0);
    mod_off = 1'b0;
    repeat (50) @(negedge clk);
    #1;
    chk("R2 legs complementary", int'(tx_a ^ tx_b), 1);

    freq_sel = 2'd1;
    off1 = 63;
    wait_strobes(3);
    strobe_gap(gap);
    chk("R1 period sel01", gap, 64);
    chk("R5 phase sel01", int'(phase_code), 63);

    tx_dis = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R3 drivers off", int'(tx_a | tx_b), 0);
    repeat (5) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule